// File: doc/BRIEF.md
# FIFO-Fed Pulse-Width Modulator

This block generates a pulse-width modulated output from a stream of duty values. Software writes each duty value into a four-entry queue over a small register bus. A prescaled period counter runs over a span set by the period register. Each time the counter rolls over, the next queued value, if there is one, becomes the compare value for the new period. The output is active while the count is below that compare value.

A two-bit mode field sets the output sense: normal, inverted, or off. The enable bit is a hard gate. When it is clear, the pin is low in every mode. A zero duty value, by contrast, parks the pin at the inactive level that matches the mode, so an inverted output can be idled high without being disabled. The status register reports how full the queue is and whether a write was lost. A self-clearing software reset returns the control register, the queue and the counters to their idle state.

Top module: `pwm_fifo_top`

## Requirements
- R1: While control bit 0 (enable) is 0, the output pin is low whatever the mode field holds.
- R2: With mode field control[5:4] = 00, the pin is high while the period count is below the compare value. For a compare value S with 0 < S <= P, one period gives S*(D+1) high clocks.
- R3: Mode 01 gives the complement of mode 00. Modes 10 and 11 hold the pin low.
- R4: A compare value of zero gives no waveform. The pin stays low in mode 00 and high in mode 01.
- R5: A compare value greater than the period register P keeps the pin at the active level for the whole period.
- R6: Writes to address 0x8 push into a 4-entry queue. Status register (address 0x4) bits [2:0] give the number of filled entries.
- R7: A write to a full queue is dropped and sets sticky status bit 3. Writing 1 to status bit 3 clears it and leaves the queue unchanged.
- R8: Writing 1 to control bit 1 clears the control register, the queue, the overflow bit, the counters and the compare value at that clock edge. Bit 1 reads 1 for one cycle and then 0. The period register keeps its value.
- R9: The prescaler field control[17:6] divides the clock by D+1. The counter runs 0..P+2 (P from address 0xC), so one period lasts (P+3)*(D+1) clocks.
- R10: At each rollover the oldest queued value becomes the compare value. With the queue empty, the previous compare value is kept. Reading address 0x8 returns the current compare value.
- R11: With clock-source field control[3:2] = 00, the counter and prescaler are held at zero, so no rollover and no queue pop take place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address (0x0 control, 0x4 status, 0x8 sample, 0xC period) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the addressed register |
| pwm_o | output | 1 | Modulated output pin |

## Verification
The bench measures the high time over a full period for each combination of mode, prescaler, period and duty. A design that counted the wrong period span or compared at the wrong edge would show an off-by-one in these measurements. Zero and oversized duty values are checked in both polarities: a design that gated the pin with the duty value instead of the mode would leave an inverted output low when it should idle high, and a design that did not saturate would pulse short. The queue is overfilled to show that a lost write sets the sticky flag and leaves the fill at four. The software reset bit is read in the cycle straight after its write and again one cycle later, which catches a bit that never clears or a flush that arrives one cycle late. Separate tests check that the compare value follows the queue in order and holds when the queue runs dry, and that the counter stays stopped when the clock source is off.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    localparam int PRE_W = 12;

    typedef struct packed {
        logic [PRE_W-1:0] presc;
        logic [1:0]       mode;
        logic [1:0]       clksrc;
        logic             swr;
        logic             en;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam logic [1:0] MODE_NORMAL = 2'b00;
    localparam logic [1:0] MODE_INVERT = 2'b01;

    localparam logic [1:0] RA_CTRL   = 2'd0;
    localparam logic [1:0] RA_STATUS = 2'd1;
    localparam logic [1:0] RA_SAMPLE = 2'd2;
    localparam logic [1:0] RA_PERIOD = 2'd3;
endpackage

// File: rtl/pwm_sample_fifo.sv
module pwm_sample_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            push,
    input  logic [W-1:0]    push_data,
    input  logic            pop,
    output logic [W-1:0]    head,
    output logic [CNTW-1:0] count,
    output logic            full,
    output logic            empty
);
    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           rd;
        logic [AW-1:0]           wr;
        logic [CNTW-1:0]         cnt;
    } fifo_t;

    fifo_t st_d, st_q;
    logic  do_push, do_pop;

    assign full  = (32'(st_q.cnt) == DEPTH);
    assign empty = (st_q.cnt == '0);
    assign head  = st_q.mem[st_q.rd];
    assign count = st_q.cnt;

    always_comb begin
        st_d    = st_q;
        do_push = push && !full;
        do_pop  = pop && !empty;
        if (flush) begin
            st_d.rd  = '0;
            st_d.wr  = '0;
            st_d.cnt = '0;
        end else begin
            if (do_push) begin
                st_d.mem[st_q.wr] = push_data;
                st_d.wr = (32'(st_q.wr) == DEPTH - 1) ? '0 : st_q.wr + 1'b1;
            end
            if (do_pop) begin
                st_d.rd = (32'(st_q.rd) == DEPTH - 1) ? '0 : st_q.rd + 1'b1;
            end
            st_d.cnt = st_q.cnt + CNTW'(do_push) - CNTW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        32'(count) <= DEPTH); // R6
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> (32'(count) == DEPTH)); // R7
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
    parameter int PW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [PW-1:0] limit,
    output logic          tick
);
    logic [PW-1:0] cnt_d, cnt_q;

    assign tick = run && (cnt_q >= limit);

    always_comb begin
        cnt_d = cnt_q;
        if (!run)      cnt_d = '0;
        else if (tick) cnt_d = '0;
        else           cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (limit == '0) || !tick); // R9
endmodule

// File: rtl/pwm_fifo_top.sv
module pwm_fifo_top
    import pwm_pkg::*;
#(
    parameter int PER_W = 16,
    parameter int SMP_W = 16,
    parameter int DEPTH = 4,
    localparam int CW   = PER_W + 1,
    localparam int FCW  = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [3:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        pwm_o
);
    typedef struct packed {
        ctrl_t            ctrl;
        logic [PER_W-1:0] period;
        logic [SMP_W-1:0] cmp;
        logic [CW-1:0]    cnt;
        logic             ovf;
    } state_t;

    state_t st_d, st_q;

    logic             wr_en, swr_wr, running, tick, wrap, act;
    logic             push, pop, f_full, f_empty;
    logic [SMP_W-1:0] f_head;
    logic [FCW-1:0]   f_count;
    logic [CW-1:0]    cnt_end;
    logic [1:0]       ra;

    assign ra      = bus_addr[3:2];
    assign wr_en   = bus_sel && bus_wr;
    assign swr_wr  = wr_en && (ra == RA_CTRL) && bus_wdata[1];
    assign running = st_q.ctrl.en && (st_q.ctrl.clksrc != 2'b00);
    assign cnt_end = CW'(st_q.period) + CW'(2);
    assign wrap    = tick && (st_q.cnt >= cnt_end);
    assign push    = wr_en && (ra == RA_SAMPLE) && !swr_wr;
    assign pop     = wrap && !f_empty;

    pwm_prescaler #(.PW(PRE_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (running),
        .limit (st_q.ctrl.presc),
        .tick  (tick)
    );

    pwm_sample_fifo #(.W(SMP_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (swr_wr),
        .push      (push),
        .push_data (bus_wdata[SMP_W-1:0]),
        .pop       (pop),
        .head      (f_head),
        .count     (f_count),
        .full      (f_full),
        .empty     (f_empty)
    );

    always_comb begin
        st_d = st_q;
        st_d.ctrl.swr = 1'b0;
        if (!running)  st_d.cnt = '0;
        else if (wrap) st_d.cnt = '0;
        else if (tick) st_d.cnt = st_q.cnt + 1'b1;
        if (pop) st_d.cmp = f_head;
        if (push && f_full) st_d.ovf = 1'b1;
        if (wr_en) begin
            case (ra)
                RA_CTRL:   st_d.ctrl = ctrl_t'(bus_wdata[CTRL_W-1:0] & ~CTRL_W'(2));
                RA_STATUS: if (bus_wdata[3]) st_d.ovf = 1'b0;
                RA_PERIOD: st_d.period = bus_wdata[PER_W-1:0];
                default:   ;
            endcase
        end
        if (swr_wr) begin
            st_d.ctrl     = '0;
            st_d.ctrl.swr = 1'b1;
            st_d.cnt      = '0;
            st_d.cmp      = '0;
            st_d.ovf      = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        act = (st_q.cmp != '0) &&
              ((st_q.cmp > SMP_W'(st_q.period)) || (CW'(st_q.cmp) > st_q.cnt));
        pwm_o = 1'b0;
        if (st_q.ctrl.en) begin
            if (st_q.ctrl.mode == MODE_NORMAL)      pwm_o = act;
            else if (st_q.ctrl.mode == MODE_INVERT) pwm_o = !act;
        end
    end

    always_comb begin
        case (ra)
            RA_CTRL:   bus_rdata = 32'(st_q.ctrl);
            RA_STATUS: bus_rdata = 32'({st_q.ovf, 3'(f_count)});
            RA_SAMPLE: bus_rdata = 32'(st_q.cmp);
            default:   bus_rdata = 32'(st_q.period);
        endcase
    end

    AST_PIN_LOW_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.ctrl.en |-> !pwm_o); // R1
    AST_ZERO_IDLE_INV: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.en && st_q.ctrl.mode == MODE_INVERT && st_q.cmp == '0) |-> pwm_o); // R4
    AST_SWR_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ctrl.swr |=> !st_q.ctrl.swr); // R8
    AST_SWR_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.ctrl.swr |-> (f_count == '0 && st_q.cmp == '0)); // R8
    AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wrap && !swr_wr) |=> $stable(st_q.cmp)); // R10
    AST_HALT_NO_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.clksrc == 2'b00) |=> (st_q.cnt == '0)); // R11
endmodule

// File: tb/pwm_fifo_top_tb.sv
module pwm_fifo_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pwm_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pwm_fifo_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwm_o(pwm_o)
    );

    // vector: {mode[1:0], presc[11:0], period[15:0], sample[15:0]}
    localparam int NV = 8;
    localparam logic [45:0] VEC [NV] = '{
        {2'b00, 12'd0, 16'd5, 16'd3},  // R2 normal
        {2'b00, 12'd2, 16'd5, 16'd3},  // R9 prescaled
        {2'b01, 12'd0, 16'd5, 16'd3},  // R3 inverted
        {2'b00, 12'd0, 16'd5, 16'd0},  // R4 zero, low idle
        {2'b01, 12'd0, 16'd5, 16'd0},  // R4 zero, high idle
        {2'b00, 12'd0, 16'd5, 16'd6},  // R5 oversize, full high
        {2'b01, 12'd1, 16'd4, 16'd9},  // R5 oversize inverted, full low
        {2'b10, 12'd0, 16'd5, 16'd3}   // R3 off mode
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic [31:0] ctrl_word(input logic [1:0] mode, input logic [11:0] presc,
                                              input logic [1:0] src, input logic en);
        return 32'({presc, mode, src, 1'b0, en});
    endfunction

    task automatic wait_cmp(input logic [15:0] s);
        logic [31:0] r;
        for (int i = 0; i < 4000; i++) begin
            bus_read(4'h8, r);
            if (r[15:0] == s) return;
            @(negedge clk);
        end
    endtask

    function automatic int exp_high(input logic [1:0] m, input int d, input int p, input int s);
        int hi, len;
        len = p + 3;
        hi = (s == 0) ? 0 : (s > p) ? len : s;
        if (m == 2'b00) return hi * (d + 1);
        if (m == 2'b01) return (len - hi) * (d + 1);
        return 0;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        bus_read(4'h0, r); check("R8 reset ctrl", r, 0);
        bus_read(4'h4, r); check("R6 reset status", r, 0);
        check("R1 reset pin", 32'(pwm_o), 0);

        // R1: inverted mode, zero sample, enable clear -> low; set enable -> high (R4)
        bus_write(4'h0, ctrl_word(2'b01, 12'd0, 2'b01, 1'b0));
        repeat (3) @(negedge clk);
        check("R1 disabled inverted", 32'(pwm_o), 0);
        bus_write(4'h0, ctrl_word(2'b01, 12'd0, 2'b01, 1'b1));
        check("R4 enabled inverted idle", 32'(pwm_o), 1);

        // R6/R7 queue fill and overflow
        bus_write(4'h0, 32'h2);
        for (int i = 0; i < 3; i++) bus_write(4'h8, 32'(i + 1));
        bus_read(4'h4, r); check("R6 fill three", r, 3);
        bus_write(4'h8, 32'd7);
        bus_read(4'h4, r); check("R6 fill four", r, 4);
        bus_write(4'h8, 32'd8);
        bus_read(4'h4, r); check("R7 overflow set", r, 32'h0C);
        bus_write(4'h4, 32'h8);
        bus_read(4'h4, r); check("R7 overflow cleared", r, 4);

        // R8 software reset
        bus_write(4'hC, 32'd9);
        bus_write(4'h0, 32'h2);
        bus_read(4'h0, r); check("R8 swr visible one cycle", r, 2);
        bus_read(4'h4, r); check("R8 queue flushed", r, 0);
        @(negedge clk);
        bus_read(4'h0, r); check("R8 swr self clear", r, 0);
        bus_read(4'hC, r); check("R8 period kept", r, 9);

        // R10 ordered load and hold
        bus_write(4'hC, 32'd2);
        bus_write(4'h8, 32'd1);
        bus_write(4'h8, 32'd2);
        bus_write(4'h0, ctrl_word(2'b00, 12'd0, 2'b01, 1'b1));
        for (int i = 0; i < 100; i++) begin
            bus_read(4'h8, r);
            if (r != 0) break;
            @(negedge clk);
        end
        check("R10 first load", r, 1);
        repeat (5) @(negedge clk);
        bus_read(4'h8, r); check("R10 second load", r, 2);
        repeat (20) @(negedge clk);
        bus_read(4'h8, r); check("R10 hold when empty", r, 2);
        bus_read(4'h4, r); check("R10 queue drained", r, 0);

        // R11 clock source off halts counter
        bus_write(4'h0, 32'h2);
        bus_write(4'h8, 32'd3);
        bus_write(4'h0, ctrl_word(2'b00, 12'd0, 2'b00, 1'b1));
        repeat (50) @(negedge clk);
        bus_read(4'h8, r); check("R11 no load", r, 0);
        bus_read(4'h4, r); check("R11 no pop", r, 1);

        // table: R2 R3 R4 R5 R9
        for (int v = 0; v < NV; v++) begin
            logic [1:0]  m;
            logic [11:0] d;
            logic [15:0] p, s;
            int hi, len;
            {m, d, p, s} = VEC[v];
            bus_write(4'h0, 32'h2);
            bus_write(4'hC, 32'(p));
            bus_write(4'h8, 32'(s));
            bus_write(4'h0, ctrl_word(m, d, 2'b01, 1'b1));
            wait_cmp(s);
            len = (int'(p) + 3) * (int'(d) + 1);
            hi = 0;
            for (int k = 0; k < len; k++) begin
                if (pwm_o) hi++;
                @(negedge clk);
            end
            check($sformatf("R2/R3/R4/R5/R9 vector %0d high clocks", v),
                  32'(hi), 32'(exp_high(m, int'(d), int'(p), int'(s))));
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule